// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit sits beside an I2C master's bus engine and gathers its event pulses into sticky status flags. Software sees those flags two ways. The first is a status word that it clears by writing ones, paired with an enable mask that drives one interrupt line. The second is a legacy vector code that names the most urgent pending event, and reading the code also acknowledges that event.

The bus engine sends single-cycle pulses for these events: arbitration lost, missing acknowledge, access ready, receive ready, transmit ready, receive overrun and transmit underflow. It also drives a bus-busy level. A small register port selects one of three registers. The read data follows the select input combinationally. A write takes effect at the clock edge. A read strobe only matters for the vector register, where it triggers the acknowledge.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset, the enable register, every sticky status bit, the vector code and the interrupt line are all zero.
- R2: Each event pulse sets a sticky status bit at a fixed position: arbitration lost bit 0, no acknowledge bit 1, access ready bit 2, receive ready bit 3, transmit ready bit 4, transmit underflow bit 10, receive overrun bit 11. Bits 8, 9 and 15 read as zero.
- R3: Status bit 12 follows the bus-busy input live in the same cycle. Writing to it has no effect, and it never raises the interrupt line.
- R4: The register select decodes as follows: 0 is enable, 1 is status, 2 is vector, and 3 reads as zero. Only enable bits 4:0 can be written; its other bits read as zero.
- R5: Writing the status register clears each sticky bit whose write-data bit is 1. A bit written with 0 keeps its value.
- R6: When an event and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.
- R7: The interrupt line is registered. It goes high one cycle after any of status bits 4:0 is set together with its enable bit, and it falls one cycle after no such pair remains.
- R8: The vector register reads 1 for arbitration lost, 2 for no acknowledge, 3 for access ready, 4 for receive ready, 5 for transmit ready and 0 when none is pending. When several are pending, the lowest code is returned. The enable mask does not affect the vector.
- R9: A read strobe on the vector register clears exactly the status bit named by the code returned, at that clock edge. All other bits keep their values.
- R10: Overrun and underflow never appear in the vector code and never raise the interrupt line.
- R11: A vector read while nothing is pending returns 0 and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_arb_lost | input | 1 | Arbitration-lost event pulse |
| ev_nack | input | 1 | No-acknowledge event pulse |
| ev_acc_rdy | input | 1 | Access-ready event pulse |
| ev_rx_rdy | input | 1 | Receive-ready event pulse |
| ev_tx_rdy | input | 1 | Transmit-ready event pulse |
| ev_rx_ovr | input | 1 | Receive-overrun event pulse |
| ev_tx_udf | input | 1 | Transmit-underflow event pulse |
| bus_busy | input | 1 | Live bus-busy level |
| reg_sel | input | 2 | Register select (0 enable, 1 status, 2 vector) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (acknowledges on vector) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the selected register |
| irq | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach is a collision: an event pulse in the same cycle as a clear of the same bit. The bench drives the event input and the status write on one clock edge, then reads the bit back. A vector acknowledge racing several pending sources is also hard to reach. The bench loads three sources with the enable mask at zero, so the interrupt line cannot mask the order. It then walks the vector reads one by one and checks both the returned code and the remaining status after each acknowledge.

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector #(
  parameter int DW    = 16,
  parameter int SEL_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_arb_lost,
  input  logic          ev_nack,
  input  logic          ev_acc_rdy,
  input  logic          ev_rx_rdy,
  input  logic          ev_tx_rdy,
  input  logic          ev_rx_ovr,
  input  logic          ev_tx_udf,
  input  logic          bus_busy,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int NSRC  = 5;
  localparam int VEC_W = $clog2(NSRC + 1);
  localparam int B_UDF = 10;
  localparam int B_OVR = 11;
  localparam int B_BSY = 12;
  localparam logic [SEL_W-1:0] SEL_EN  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_ST  = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_VEC = SEL_W'(2);

  logic [NSRC-1:0]  en_q, src_q, vec_hit, clr_src;
  logic             ovr_q, udf_q, irq_q;
  logic [VEC_W-1:0] vcode;
  logic [DW-1:0]    stat_word;

  wire [NSRC-1:0] src_ev = {ev_tx_rdy, ev_rx_rdy, ev_acc_rdy, ev_nack, ev_arb_lost};
  wire wr_en  = reg_wr && (reg_sel == SEL_EN);
  wire wr_st  = reg_wr && (reg_sel == SEL_ST);
  wire rd_vec = reg_rd && (reg_sel == SEL_VEC);

  always_comb begin
    vcode   = '0;
    vec_hit = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src_q[i]) begin
        vcode   = VEC_W'(i + 1);
        vec_hit = NSRC'(1) << i;
      end
    end
  end

  assign clr_src = (wr_st ? reg_wdata[NSRC-1:0] : '0) | (rd_vec ? vec_hit : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      src_q <= '0;
      ovr_q <= 1'b0;
      udf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= reg_wdata[NSRC-1:0];
      src_q <= (src_q & ~clr_src) | src_ev;
      ovr_q <= (ovr_q & ~(wr_st & reg_wdata[B_OVR])) | ev_rx_ovr;
      udf_q <= (udf_q & ~(wr_st & reg_wdata[B_UDF])) | ev_tx_udf;
      irq_q <= |(src_q & en_q);
    end
  end

  always_comb begin
    stat_word             = '0;
    stat_word[NSRC-1:0]   = src_q;
    stat_word[B_UDF]      = udf_q;
    stat_word[B_OVR]      = ovr_q;
    stat_word[B_BSY]      = bus_busy;
  end

  always_comb begin
    case (reg_sel)
      SEL_EN:  reg_rdata = {{(DW-NSRC){1'b0}}, en_q};
      SEL_ST:  reg_rdata = stat_word;
      SEL_VEC: reg_rdata = {{(DW-VEC_W){1'b0}}, vcode};
      default: reg_rdata = '0;
    endcase
  end

  assign irq = irq_q;

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> src_q[1]);

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && reg_wdata[0] && !ev_arb_lost) |=> !src_q[0]);

  assert_zero_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q[2] && !(wr_st && reg_wdata[2]) && !(rd_vec && vcode == VEC_W'(3))) |=> src_q[2]);

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && reg_wdata[3] && ev_rx_rdy) |=> src_q[3]);

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(src_q & en_q)));

  assert_vec_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && vcode == VEC_W'(1) && !ev_arb_lost) |=> !src_q[0]);

  assert_vec_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && src_q == '0 && src_ev == '0 && !wr_st) |=> $stable(src_q));
endmodule

// File: tb/i2c_irq_vector_test.sv
module i2c_irq_vector_test;
  logic clk = 0, rst_n = 0;
  logic ev_al = 0, ev_nk = 0, ev_ar = 0, ev_rr = 0, ev_xr = 0, ev_ov = 0, ev_ud = 0;
  logic busy = 0;
  logic [1:0] sel = 0;
  logic wr = 0, rd = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  i2c_irq_vector uut (
    .clk(clk), .rst_n(rst_n),
    .ev_arb_lost(ev_al), .ev_nack(ev_nk), .ev_acc_rdy(ev_ar),
    .ev_rx_rdy(ev_rr), .ev_tx_rdy(ev_xr), .ev_rx_ovr(ev_ov), .ev_tx_udf(ev_ud),
    .bus_busy(busy), .reg_sel(sel), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(logic [6:0] m);
    {ev_ud, ev_ov, ev_xr, ev_rr, ev_ar, ev_nk, ev_al} = m;
    tick();
    {ev_ud, ev_ov, ev_xr, ev_rr, ev_ar, ev_nk, ev_al} = '0;
  endtask

  task automatic wreg(logic [1:0] s, logic [15:0] d);
    sel = s; wdata = d; wr = 1;
    tick();
    wr = 0; wdata = 0;
  endtask

  task automatic peek(logic [1:0] s, output logic [15:0] d);
    sel = s; #1; d = rdata;
  endtask

  task automatic rvec(output logic [15:0] d);
    sel = 2; rd = 1; #1; d = rdata;
    tick();
    rd = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    peek(0, d); check("R1 enable", d, 16'h0000);
    peek(1, d); check("R1 status", d, 16'h0000);
    peek(2, d); check("R1 vector", d, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_positions();
    logic [15:0] d;
    logic [15:0] exp [7] = '{16'h0001, 16'h0002, 16'h0004, 16'h0008, 16'h0010, 16'h0800, 16'h0400};
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1) << i);
      peek(1, d); check("R2 position", d, exp[i]);
      wreg(1, 16'hFFFF);
      peek(1, d); check("R5 clear all", d, 16'h0000);
    end
  endtask

  task automatic t_busy();
    logic [15:0] d;
    wreg(0, 16'h001F);
    busy = 1; #1;
    peek(1, d); check("R3 busy live", d, 16'h1000);
    wreg(1, 16'h1000);
    peek(1, d); check("R3 busy write ignored", d, 16'h1000);
    tick();
    check("R3 busy no irq", {15'b0, irq}, 16'h0000);
    busy = 0; #1;
    peek(1, d); check("R3 busy falls", d, 16'h0000);
    wreg(0, 16'h0000);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    wreg(0, 16'hFFFF);
    peek(0, d); check("R4 enable mask", d, 16'h001F);
    peek(3, d); check("R4 unused select", d, 16'h0000);
    wreg(0, 16'h0000);
    peek(0, d); check("R4 enable clear", d, 16'h0000);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    pulse(7'b0001011);
    wreg(1, 16'h0002);
    peek(1, d); check("R5 selective clear", d, 16'h0009);
    wreg(1, 16'h0000);
    peek(1, d); check("R5 zero keeps", d, 16'h0009);
    wreg(1, 16'hFFFF);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    pulse(7'b0000010);
    ev_nk = 1;
    wreg(1, 16'h0002);
    ev_nk = 0;
    peek(1, d); check("R6 event wins", d, 16'h0002);
    wreg(1, 16'hFFFF);
    peek(1, d); check("R6 later clear", d, 16'h0000);
  endtask

  task automatic t_irq();
    wreg(0, 16'h0004);
    pulse(7'b0001000);
    tick();
    check("R7 masked no irq", {15'b0, irq}, 16'h0000);
    pulse(7'b0000100);
    check("R7 irq registered delay", {15'b0, irq}, 16'h0000);
    tick();
    check("R7 irq high", {15'b0, irq}, 16'h0001);
    wreg(1, 16'h0004);
    check("R7 irq held one cycle", {15'b0, irq}, 16'h0001);
    tick();
    check("R7 irq falls", {15'b0, irq}, 16'h0000);
    wreg(1, 16'hFFFF);
    wreg(0, 16'h0000);
  endtask

  task automatic t_vector();
    logic [15:0] d;
    pulse(7'b0011010);
    rvec(d); check("R8 vector lowest nack", d, 16'h0002);
    peek(1, d); check("R9 only nack cleared", d, 16'h0018);
    rvec(d); check("R8 vector rx ready", d, 16'h0004);
    rvec(d); check("R8 vector tx ready", d, 16'h0005);
    rvec(d); check("R11 vector empty", d, 16'h0000);
    peek(1, d); check("R11 status unchanged", d, 16'h0000);
    pulse(7'b0000101);
    rvec(d); check("R8 vector arb lost", d, 16'h0001);
    rvec(d); check("R8 vector access ready", d, 16'h0003);
    peek(1, d); check("R9 all acked", d, 16'h0000);
  endtask

  task automatic t_ovr();
    logic [15:0] d;
    wreg(0, 16'h001F);
    pulse(7'b1100000);
    peek(2, d); check("R10 vector excludes", d, 16'h0000);
    tick();
    check("R10 no irq", {15'b0, irq}, 16'h0000);
    rvec(d);
    peek(1, d); check("R10 flags kept", d, 16'h0C00);
    wreg(1, 16'h0800);
    peek(1, d); check("R10 overrun cleared", d, 16'h0400);
    wreg(1, 16'hFFFF);
    wreg(0, 16'h0000);
  endtask

  initial begin
    fork
      begin
        repeat (3) tick();
        t_reset();
        rst_n = 1;
        tick();
        t_reset();
        t_positions();
        t_busy();
        t_enable();
        t_w1c();
        t_collide();
        t_irq();
        t_vector();
        t_ovr();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=hang exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule